// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a serial chain of boundary cells placed between the core logic and the device pins. It serves two kinds of pins. A dedicated input pin gets one cell. A bidirectional pin gets two cells: a control cell that decides whether the pin is driven, and a data cell that holds the driven value and observes the pin level. A pin that is only an output is connected as a bidirectional pin whose level is simply not used. Every cell has a shift flip-flop and an update latch behind it. A test port controller supplies the capture, shift and update state flags and three decoded instruction flags.

With no test instruction active, the cells are transparent and functional signals pass straight through. The sample instruction records the live pin states while the device keeps running, and the shifted data is staged into the update latches without touching the pins. The external-test instruction cuts the core off from the pins. The pins are then driven from the update latches and the input pins are observed. The clamp instruction holds the pins at the values already in the update latches and freezes the chain against any further capture, shift or update.

The test controller selects at most one instruction at a time. If more than one flag is raised, external test takes precedence over clamp, and clamp takes precedence over sample.

Top module: `bsr_chain`

## Requirements
- R1: While rst_n is low, so_o is 0 and every update latch is 0, with the clear taking effect asynchronously. Internally, reset is released two rising clk edges after rst_n goes high.
- R2: With no instruction flag raised, pin_out_o equals core_out_i, pin_oe_o equals core_oe_i, and core_in_o equals pin_in_i.
- R3: On a rising edge with capture_i high under sample or external test, the shift stages load the capture vector. Bit i (i < N_IN) holds pin_in_i[i]. Bit N_IN+2j holds core_oe_i[j], and bit N_IN+2j+1 holds pin_bidi_i[j].
- R4: On a rising edge with shift_i high under sample or external test, every stage k takes stage k+1, the last stage takes si_i, and so_o always shows stage 0. The chain length is N_IN+2*N_BIDI. If capture_i and shift_i are both high in the same cycle, the capture wins.
- R5: The update latches load from the shift stages only on the falling clk edge of a cycle with update_i high under sample or external test. Otherwise they hold, and pin outputs change only at that falling edge.
- R6: Under sample, the pins and core_in_o behave as in R2, including across a preload through update_i.
- R7: Under external test, pin_out_o[j] is the data latch (bit N_IN+2j+1) and pin_oe_o[j] is the control latch (bit N_IN+2j). A control value of 1 drives the pin and 0 gives high impedance. core_in_o[i] is the input latch (bit i).
- R8: Under clamp, pin_out_o and pin_oe_o come from the latches as in R7, and core_in_o follows pin_in_i. capture_i, shift_i and update_i have no effect on the shift stages or the latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low test reset |
| ins_extest_i | input | 1 | External-test instruction decoded |
| ins_sample_i | input | 1 | Sample/preload instruction decoded |
| ins_clamp_i | input | 1 | Clamp instruction decoded |
| capture_i | input | 1 | Controller is in the data capture state |
| shift_i | input | 1 | Controller is in the data shift state |
| update_i | input | 1 | Controller is in the data update state |
| si_i | input | 1 | Serial data into the far end of the chain |
| so_o | output | 1 | Serial data out of cell 0 |
| pin_in_i | input | N_IN | Levels on the dedicated input pins |
| core_in_o | output | N_IN | Input values presented to the core |
| core_out_i | input | N_BIDI | Core output values for the bidirectional pins |
| core_oe_i | input | N_BIDI | Core output enables for the bidirectional pins |
| pin_bidi_i | input | N_BIDI | Levels observed on the bidirectional pins |
| pin_out_o | output | N_BIDI | Value driven toward the bidirectional pins |
| pin_oe_o | output | N_BIDI | Enables of the bidirectional pin drivers |

## Verification
Capture and shift can both be requested on the same rising edge. The bench raises both flags after loading the chain with a vector that differs from the capture vector. It then shifts the contents out and requires the captured pattern rather than the shifted one. The other overlap is an update under sample while the core is driving the pins. The bench checks that the pins keep core values through the preload, and that the preloaded values appear only once external test is selected. Under external test it also samples the pins between the rising and falling edges of an update cycle, to show that the latches move only at the falling edge.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    INSN_FUNC   = 2'd0,
    INSN_SAMPLE = 2'd1,
    INSN_EXTEST = 2'd2,
    INSN_CLAMP  = 2'd3
  } bsr_insn_e;

  localparam logic CTL_DRIVE = 1'b1;

  function automatic int ctl_pos(input int n_in, input int j);
    return n_in + 2 * j;
  endfunction

  function automatic int dat_pos(input int n_in, input int j);
    return n_in + 2 * j + 1;
  endfunction

endpackage

// File: rtl/bsr_shift_stage.sv
module bsr_shift_stage #(
  parameter int LEN = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_en,
  input  logic           shift_en,
  input  logic           si,
  input  logic [LEN-1:0] cap_vec,
  output logic [LEN-1:0] stage
);

  logic [LEN-1:0] stage_nx;
  logic           stage_en;

  assign stage_en = cap_en | shift_en;

  always_comb begin
    stage_nx = stage;
    if (cap_en) begin
      stage_nx = cap_vec;
    end else if (shift_en) begin
      for (int k = 0; k < LEN - 1; k++) begin
        stage_nx[k] = stage[k+1];
      end
      stage_nx[LEN-1] = si;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
    end else if (stage_en) begin
      stage <= stage_nx;
    end
  end

  a_r3_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> stage == $past(cap_vec));

  a_r4_shift_move: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cap_en) |=> (stage[LEN-1] == $past(si)) &&
                               (stage[LEN-2:0] == $past(stage[LEN-1:1])));

  a_r8_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !cap_en) |=> $stable(stage));

endmodule

// File: rtl/bsr_update_bank.sv
module bsr_update_bank #(
  parameter int LEN = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd_en,
  input  logic [LEN-1:0] stage,
  output logic [LEN-1:0] latch
);

  logic [LEN-1:0] latch_nx;

  always_comb begin
    latch_nx = latch;
    if (upd_en) begin
      latch_nx = stage;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch <= '0;
    end else if (upd_en) begin
      latch <= latch_nx;
    end
  end

  a_r5_latch_hold: assert property (@(negedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(latch));

  a_r5_latch_load: assert property (@(negedge clk) disable iff (!rst_n)
    upd_en |=> latch == $past(stage));

endmodule

// File: rtl/bsr_pin_mux.sv
module bsr_pin_mux
  import bsr_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_BIDI = 2,
  localparam int LEN   = N_IN + 2 * N_BIDI
) (
  input  bsr_insn_e         insn,
  input  logic [LEN-1:0]    latch,
  input  logic [N_IN-1:0]   pin_in_i,
  input  logic [N_BIDI-1:0] core_out_i,
  input  logic [N_BIDI-1:0] core_oe_i,
  input  logic [N_BIDI-1:0] pin_bidi_i,
  output logic [N_IN-1:0]   core_in_o,
  output logic [N_BIDI-1:0] pin_out_o,
  output logic [N_BIDI-1:0] pin_oe_o,
  output logic [LEN-1:0]    cap_vec
);

  logic core_cut;
  logic test_drive;

  assign core_cut   = (insn == INSN_EXTEST);
  assign test_drive = (insn == INSN_EXTEST) || (insn == INSN_CLAMP);

  for (genvar i = 0; i < N_IN; i++) begin : g_in_cell
    assign cap_vec[i]   = pin_in_i[i];
    assign core_in_o[i] = core_cut ? latch[i] : pin_in_i[i];
  end

  for (genvar j = 0; j < N_BIDI; j++) begin : g_bidi_cell
    localparam int CP = ctl_pos(N_IN, j);
    localparam int DP = dat_pos(N_IN, j);
    assign cap_vec[CP]  = core_oe_i[j];
    assign cap_vec[DP]  = pin_bidi_i[j];
    assign pin_out_o[j] = test_drive ? latch[DP] : core_out_i[j];
    assign pin_oe_o[j]  = test_drive ? (latch[CP] == CTL_DRIVE) : core_oe_i[j];
  end

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int N_IN   = 3,
  parameter int N_BIDI = 2,
  localparam int LEN   = N_IN + 2 * N_BIDI
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_extest_i,
  input  logic              ins_sample_i,
  input  logic              ins_clamp_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              si_i,
  output logic              so_o,
  input  logic [N_IN-1:0]   pin_in_i,
  output logic [N_IN-1:0]   core_in_o,
  input  logic [N_BIDI-1:0] core_out_i,
  input  logic [N_BIDI-1:0] core_oe_i,
  input  logic [N_BIDI-1:0] pin_bidi_i,
  output logic [N_BIDI-1:0] pin_out_o,
  output logic [N_BIDI-1:0] pin_oe_o
);

  logic [1:0]      rst_q;
  logic            rst_s_n;
  bsr_insn_e       insn;
  logic            chain_sel;
  logic            cap_en;
  logic            shift_en;
  logic            upd_en;
  logic [LEN-1:0]  stage;
  logic [LEN-1:0]  latch;
  logic [LEN-1:0]  cap_vec;
  logic [N_BIDI-1:0] ctl_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end

  assign rst_s_n = rst_q[1];

  always_comb begin
    if (ins_extest_i) begin
      insn = INSN_EXTEST;
    end else if (ins_clamp_i) begin
      insn = INSN_CLAMP;
    end else if (ins_sample_i) begin
      insn = INSN_SAMPLE;
    end else begin
      insn = INSN_FUNC;
    end
  end

  assign chain_sel = (insn == INSN_EXTEST) || (insn == INSN_SAMPLE);
  assign cap_en    = chain_sel && capture_i;
  assign shift_en  = chain_sel && shift_i;
  assign upd_en    = chain_sel && update_i;

  bsr_shift_stage #(.LEN(LEN)) u_shift (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .cap_en   (cap_en),
    .shift_en (shift_en),
    .si       (si_i),
    .cap_vec  (cap_vec),
    .stage    (stage)
  );

  bsr_update_bank #(.LEN(LEN)) u_update (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .upd_en (upd_en),
    .stage  (stage),
    .latch  (latch)
  );

  bsr_pin_mux #(.N_IN(N_IN), .N_BIDI(N_BIDI)) u_mux (
    .insn       (insn),
    .latch      (latch),
    .pin_in_i   (pin_in_i),
    .core_out_i (core_out_i),
    .core_oe_i  (core_oe_i),
    .pin_bidi_i (pin_bidi_i),
    .core_in_o  (core_in_o),
    .pin_out_o  (pin_out_o),
    .pin_oe_o   (pin_oe_o),
    .cap_vec    (cap_vec)
  );

  assign so_o = stage[0];

  for (genvar j = 0; j < N_BIDI; j++) begin : g_ctl
    assign ctl_bits[j] = latch[ctl_pos(N_IN, j)];
  end

  a_r2_transparent: assert property (@(posedge clk) disable iff (!rst_s_n)
    (insn == INSN_FUNC) |-> (pin_out_o == core_out_i) && (pin_oe_o == core_oe_i) &&
                            (core_in_o == pin_in_i));

  a_r6_sample_functional: assert property (@(posedge clk) disable iff (!rst_s_n)
    (insn == INSN_SAMPLE) |-> (pin_out_o == core_out_i) && (pin_oe_o == core_oe_i) &&
                              (core_in_o == pin_in_i));

  a_r7_hiz_on_disable: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((insn == INSN_EXTEST) || (insn == INSN_CLAMP)) |-> ((pin_oe_o & ~ctl_bits) == '0));

  a_r8_clamp_pins_steady: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((insn == INSN_CLAMP) && $past(insn == INSN_CLAMP)) |->
      ($stable(pin_out_o) && $stable(pin_oe_o)));

  a_r4_so_tracks_stage: assert property (@(posedge clk) disable iff (!rst_s_n)
    (shift_en && !cap_en) |=> so_o == $past(stage[1]));

endmodule

// File: tb/bsr_chain_tb.sv
module bsr_chain_tb;

  localparam int CLK_P  = 10;
  localparam int N_IN   = 3;
  localparam int N_BIDI = 2;
  localparam int LEN    = N_IN + 2 * N_BIDI;

  logic clk = 1'b0;
  logic rst_n;
  logic ins_extest, ins_sample, ins_clamp;
  logic capture, shift, update, si;
  logic so;
  logic [N_IN-1:0]   pin_in, core_in;
  logic [N_BIDI-1:0] core_out, core_oe, pin_bidi, pin_out, pin_oe;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bsr_chain #(.N_IN(N_IN), .N_BIDI(N_BIDI)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ins_extest_i (ins_extest),
    .ins_sample_i (ins_sample),
    .ins_clamp_i  (ins_clamp),
    .capture_i    (capture),
    .shift_i      (shift),
    .update_i     (update),
    .si_i         (si),
    .so_o         (so),
    .pin_in_i     (pin_in),
    .core_in_o    (core_in),
    .core_out_i   (core_out),
    .core_oe_i    (core_oe),
    .pin_bidi_i   (pin_bidi),
    .pin_out_o    (pin_out),
    .pin_oe_o     (pin_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  task automatic cyc();
    @(posedge clk);
    #(CLK_P - 2);
  endtask

  function automatic logic [LEN-1:0] cap_exp();
    logic [LEN-1:0] v;
    for (int i = 0; i < N_IN; i++) v[i] = pin_in[i];
    for (int j = 0; j < N_BIDI; j++) begin
      v[N_IN + 2*j]     = core_oe[j];
      v[N_IN + 2*j + 1] = pin_bidi[j];
    end
    return v;
  endfunction

  function automatic logic [N_BIDI-1:0] exp_out(input logic [LEN-1:0] v);
    logic [N_BIDI-1:0] r;
    for (int j = 0; j < N_BIDI; j++) r[j] = v[N_IN + 2*j + 1];
    return r;
  endfunction

  function automatic logic [N_BIDI-1:0] exp_oe(input logic [LEN-1:0] v);
    logic [N_BIDI-1:0] r;
    for (int j = 0; j < N_BIDI; j++) r[j] = v[N_IN + 2*j];
    return r;
  endfunction

  task automatic set_insn(input logic e, input logic s, input logic c);
    ins_extest = e;
    ins_sample = s;
    ins_clamp  = c;
  endtask

  task automatic drive_pins(input int p);
    logic [6:0] v;
    v = 7'(p);
    pin_in   = v[2:0];
    core_oe  = v[4:3];
    core_out = v[6:5];
    pin_bidi = v[1:0] ^ v[6:5];
  endtask

  // capture, LEN shifts, optional update
  task automatic dr_scan(input logic [LEN-1:0] din, output logic [LEN-1:0] dout, input bit do_upd);
    capture = 1'b1;
    cyc();
    capture = 1'b0;
    shift   = 1'b1;
    for (int k = 0; k < LEN; k++) begin
      si      = din[k];
      dout[k] = so;
      cyc();
    end
    shift = 1'b0;
    if (do_upd) begin
      update = 1'b1;
      cyc();
      update = 1'b0;
    end
  endtask

  task automatic check_test_pins(input logic [LEN-1:0] v, input string req);
    chk(pin_out === exp_out(v), req, 32'(pin_out), 32'(exp_out(v)));
    chk(pin_oe === exp_oe(v), req, 32'(pin_oe), 32'(exp_oe(v)));
  endtask

  task automatic check_functional(input string req);
    chk((pin_out === core_out) && (pin_oe === core_oe) && (core_in === pin_in), req,
        32'({pin_out, pin_oe, core_in}), 32'({core_out, core_oe, pin_in}));
  endtask

  initial begin
    logic [LEN-1:0] dout;
    logic [LEN-1:0] cap;
    logic [LEN-1:0] held;
    rst_n = 1'b0;
    set_insn(0, 0, 0);
    capture = 0; shift = 0; update = 0; si = 0;
    drive_pins(0);
    repeat (3) cyc();
    // R1: reset state
    chk(so === 1'b0, "R1 so in reset", 32'(so), 0);
    check_functional("R1 functional in reset");
    rst_n = 1'b1;
    repeat (3) cyc();

    // R2: transparent sweep over all inputs
    for (int p = 0; p < 128; p++) begin
      drive_pins(p);
      #1;
      check_functional("R2 transparent");
    end

    // R3/R6: sample captures and preloads without disturbing pins
    set_insn(0, 1, 0);
    for (int p = 0; p < 16; p++) begin
      drive_pins(p * 37 + 5);
      cap = cap_exp();
      held = LEN'(p * 23 + 9);
      dr_scan(held, dout, 1'b1);
      chk(dout === cap, "R3 sample capture", 32'(dout), 32'(cap));
      check_functional("R6 sample keeps pins functional");
    end

    // R7: preloaded values appear once external test is selected
    set_insn(1, 0, 0);
    #1;
    check_test_pins(held, "R7 preload reaches pins");
    chk(core_in === held[N_IN-1:0], "R7 core input from latch", 32'(core_in), 32'(held[N_IN-1:0]));

    // R3/R4/R7: external test sweep over every vector
    for (int v = 0; v < (1 << LEN); v++) begin
      drive_pins(v * 11 + 3);
      cap = cap_exp();
      dr_scan(LEN'(v), dout, 1'b1);
      chk(dout === cap, "R4 shift out captured vector", 32'(dout), 32'(cap));
      check_test_pins(LEN'(v), "R7 extest drive and hi-z");
      chk(core_in === v[N_IN-1:0], "R7 core input from latch", 32'(core_in), 32'(v[N_IN-1:0]));
    end

    // R5: pins change only at the falling edge of the update cycle
    held = 7'b1011010;
    dr_scan(held, dout, 1'b0);
    check_test_pins(LEN'((1 << LEN) - 1), "R5 no change before update");
    update = 1'b1;
    @(posedge clk);
    #2;
    check_test_pins(LEN'((1 << LEN) - 1), "R5 unchanged before falling edge");
    #6;
    check_test_pins(held, "R5 changed after falling edge");
    update = 1'b0;

    // R4: capture wins over shift in the same cycle
    set_insn(0, 1, 0);
    drive_pins(77);
    cap = cap_exp();
    capture = 1'b1; shift = 1'b1; si = 1'b1;
    cyc();
    capture = 1'b0;
    for (int k = 0; k < LEN; k++) begin
      si = 1'b0;
      dout[k] = so;
      cyc();
    end
    shift = 1'b0;
    chk(dout === cap, "R4 capture over shift", 32'(dout), 32'(cap));

    // R8: clamp holds pins and freezes the chain
    set_insn(1, 0, 0);
    held = 7'b0110101;
    dr_scan(held, dout, 1'b1);
    set_insn(0, 0, 1);
    #1;
    check_test_pins(held, "R8 clamp pins from latches");
    drive_pins(101);
    #1;
    chk(core_in === pin_in, "R8 core input functional", 32'(core_in), 32'(pin_in));
    capture = 1'b1;
    cyc();
    capture = 1'b0;
    shift = 1'b1; si = 1'b0;
    repeat (3) cyc();
    shift = 1'b0;
    chk(so === held[0], "R8 no capture or shift", 32'(so), 32'(held[0]));
    update = 1'b1;
    cyc();
    update = 1'b0;
    check_test_pins(held, "R8 update ignored");
    set_insn(0, 1, 0);
    shift = 1'b1;
    for (int k = 0; k < LEN; k++) begin
      si = 1'b0;
      dout[k] = so;
      cyc();
    end
    shift = 1'b0;
    chk(dout === held, "R8 stage unchanged", 32'(dout), 32'(held));

    // R1: asynchronous reset clears the latches
    set_insn(1, 0, 0);
    #1;
    check_test_pins(held, "R1 latches before reset");
    rst_n = 1'b0;
    #1;
    check_test_pins('0, "R1 latches cleared");
    chk(so === 1'b0, "R1 so cleared", 32'(so), 0);
    cyc();
    rst_n = 1'b1;
    repeat (3) cyc();
    finish_run();
  end

endmodule